// File: doc/BRIEF.md
# Ethernet Address Lookup Table Engine

This block keeps the station table of an Ethernet switch: a configurable number of 68-bit entries. Each entry holds a MAC address, an entry type and per-type attributes. Software reaches the table through a small register window. Three data words stage an entry. A table-control register commits the staged words to an index, or loads the words from an index. The same register space carries a global control register and one forwarding-state register per port. The engine-enable and VLAN-aware bits and the port states are also brought out as outputs for the forwarding logic.

The block also places new entries in hardware. A requester presents a complete 68-bit entry on a one-cycle request strobe. The engine then walks the table one entry per cycle. It picks a slot in this order: an existing address entry with the same MAC, then the lowest free slot, then the lowest ageable unicast slot. It writes the entry there and reports the chosen index. If no slot qualifies, it reports that the table is full and writes nothing. A multicast request merges its port mask with the mask of the entry it replaces. A table clear sweeps every slot back to free, one slot per cycle.

Top module: `addr_tbl_engine`

## Requirements
- R1: After reset every table entry reads as all zero (type free), every register reads zero, `busy_o` and `search_done_o` are low and `port_state_o` is zero.
- R2: Data words sit at register offsets 2, 3 and 4. Offset 2 carries entry bits 67:64 in its bits 3:0, and its other bits read zero. Offset 3 carries bits 63:32 and offset 4 carries bits 31:0. A write to the table-control register (offset 1) with bit 31 set stores the three words at the index given by the low bits.
- R3: A write to offset 1 with bit 31 clear loads the three data words from the given index. The loaded values are readable on the next cycle, and offset 1 reads back the index.
- R4: The global control register is at offset 0. Bit 31 is the engine enable, which drives `engine_en_o`. Bit 2 is VLAN-aware mode, which drives `vlan_aware_o`. All other bits except bit 30 read zero.
- R5: Port p has a control register at offset 8+p. Only its bits 1:0 are stored (0 disabled, 1 blocking, 2 learning, 3 forwarding), and they drive `port_state_o[2p+1:2p]`.
- R6: Writing offset 0 with bit 30 set while not busy writes every entry to zero, one entry per cycle. Bit 30 reads 1 and `busy_o` is high for exactly DEPTH cycles.
- R7: A placement request picks, in priority order: the entry whose type (bits 61:60) is 1 or 3 and whose bits 47:0 equal the request's bits 47:0; else the lowest entry of type 0; else the lowest entry of type 1 or 3 with bit 40 clear and bits 63:62 neither 0 nor 2. The request entry is written at the chosen index and reported on `search_idx_o`.
- R8: When no slot qualifies, `search_full_o` is high with the done pulse and no entry is written.
- R9: When the request has bit 40 set and matched an existing entry, the written bits 67:66 are the OR of the request's and the existing entry's bits 67:66.
- R10: A request is accepted only when `engine_en_o` is high and `busy_o` is low. Otherwise it has no effect. While busy, writes to offset 1 are ignored.
- R11: `search_done_o` is a one-cycle pulse. It follows the accepting edge by k+2 cycles when the match is at index k, and by DEPTH+1 cycles otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data at `reg_addr_i` (combinational) |
| search_req_i | input | 1 | Placement request strobe |
| search_entry_i | input | 68 | Entry to place |
| search_done_o | output | 1 | Placement finished (one cycle) |
| search_full_o | output | 1 | No slot found, valid with done |
| search_idx_o | output | IDX_W | Chosen index, valid with done |
| busy_o | output | 1 | Scan or clear in progress |
| engine_en_o | output | 1 | Engine enable bit |
| vlan_aware_o | output | 1 | VLAN-aware mode bit |
| port_state_o | output | 2*NUM_PORTS | Forwarding state of each port |

## Verification
The assertions assume that a request strobe is dropped once it has been accepted. They also assume that the register bus does not start a clear in the same cycle as a request the engine would otherwise take; the design gives the clear priority, and the checker models that priority. The stimulus drives every strobe for one cycle only, between clock edges. It issues requests only when the engine is idle, except in the test that probes the busy guard. Table contents are preloaded so that each placement tier is selected at least once, along with the table-full outcome and a multicast merge.

// File: rtl/atbl_pkg.sv
package atbl_pkg;
  localparam int ENTRY_W   = 68;
  localparam int MAC_W     = 48;
  localparam int MCAST_BIT = 40;

  typedef logic [ENTRY_W-1:0] entry_t;

  typedef enum logic [1:0] {ET_FREE = 2'd0, ET_ADDR = 2'd1, ET_VLAN = 2'd2, ET_VADDR = 2'd3} etype_e;
  typedef enum logic [1:0] {UT_PERSIST = 2'd0, UT_UNTOUCH = 2'd1, UT_OUI = 2'd2, UT_TOUCH = 2'd3} utype_e;

  localparam int REG_GCTL  = 0;
  localparam int REG_TCTL  = 1;
  localparam int REG_W0    = 2;
  localparam int REG_W1    = 3;
  localparam int REG_W2    = 4;
  localparam int REG_PORT0 = 8;

  localparam int GCTL_EN   = 31;
  localparam int GCTL_CLR  = 30;
  localparam int GCTL_VLAN = 2;
  localparam int TCTL_WR   = 31;

  function automatic logic ent_is_free(entry_t e);
    return e[61:60] == ET_FREE;
  endfunction

  function automatic logic ent_is_addr(entry_t e);
    return (e[61:60] == ET_ADDR) || (e[61:60] == ET_VADDR);
  endfunction

  function automatic logic ent_is_ageable(entry_t e);
    return ent_is_addr(e) && !e[MCAST_BIT] &&
           (e[63:62] != UT_PERSIST) && (e[63:62] != UT_OUI);
  endfunction
endpackage

// File: rtl/atbl_table.sv
module atbl_table
  import atbl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  entry_t           wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output entry_t           rdata_o
);
  entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/atbl_cfg.sv
module atbl_cfg
  import atbl_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int AW        = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [31:0]            wdata_i,
  output logic                   en_o,
  output logic                   vlan_o,
  output logic [2*NUM_PORTS-1:0] port_state_o
);
  logic en_q, vlan_q;
  logic gctl_hit;

  assign gctl_hit = we_i && (addr_i == AW'(REG_GCTL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      vlan_q <= 1'b0;
    end else if (gctl_hit) begin
      en_q   <= wdata_i[GCTL_EN];
      vlan_q <= wdata_i[GCTL_VLAN];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [1:0] st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= 2'd0;
      else if (we_i && (addr_i == AW'(REG_PORT0 + p))) st_q <= wdata_i[1:0];
    end
    assign port_state_o[2*p +: 2] = st_q;
  end

  assign en_o   = en_q;
  assign vlan_o = vlan_q;
endmodule

// File: rtl/atbl_scan.sv
module atbl_scan
  import atbl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  entry_t           entry_i,
  input  entry_t           rd_data_i,
  output logic [IDX_W-1:0] rd_addr_o,
  output logic             active_o,
  output logic             we_o,
  output logic [IDX_W-1:0] waddr_o,
  output entry_t           wdata_o,
  output logic             done_o,
  output logic             full_o,
  output logic [IDX_W-1:0] idx_o
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_COMMIT} state_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  state_e           state_q;
  entry_t           req_q;
  logic [IDX_W-1:0] idx_q, sel_q, free_idx_q, age_idx_q;
  logic             free_hit_q, age_hit_q, hit_q, full_q;
  logic             done_q, res_full_q;
  logic [IDX_W-1:0] res_idx_q;

  logic             cur_match, cur_free, cur_age;
  logic             free_hit_n, age_hit_n;
  logic [IDX_W-1:0] free_idx_n, age_idx_n;

  always_comb begin
    cur_match  = ent_is_addr(rd_data_i) && (rd_data_i[MAC_W-1:0] == req_q[MAC_W-1:0]);
    cur_free   = ent_is_free(rd_data_i);
    cur_age    = ent_is_ageable(rd_data_i);
    free_hit_n = free_hit_q | cur_free;
    age_hit_n  = age_hit_q  | cur_age;
    free_idx_n = free_hit_q ? free_idx_q : idx_q;
    age_idx_n  = age_hit_q  ? age_idx_q  : idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      req_q      <= '0;
      idx_q      <= '0;
      sel_q      <= '0;
      free_idx_q <= '0;
      age_idx_q  <= '0;
      free_hit_q <= 1'b0;
      age_hit_q  <= 1'b0;
      hit_q      <= 1'b0;
      full_q     <= 1'b0;
      done_q     <= 1'b0;
      res_full_q <= 1'b0;
      res_idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            req_q      <= entry_i;
            idx_q      <= '0;
            free_hit_q <= 1'b0;
            age_hit_q  <= 1'b0;
            state_q    <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (cur_match) begin
            sel_q   <= idx_q;
            hit_q   <= 1'b1;
            full_q  <= 1'b0;
            state_q <= S_COMMIT;
          end else if (idx_q == LAST_IDX) begin
            hit_q   <= 1'b0;
            full_q  <= !(free_hit_n || age_hit_n);
            sel_q   <= free_hit_n ? free_idx_n : age_idx_n;
            state_q <= S_COMMIT;
          end else begin
            idx_q      <= idx_q + 1'b1;
            free_hit_q <= free_hit_n;
            age_hit_q  <= age_hit_n;
            free_idx_q <= free_idx_n;
            age_idx_q  <= age_idx_n;
          end
        end
        S_COMMIT: begin
          done_q     <= 1'b1;
          res_full_q <= full_q;
          res_idx_q  <= sel_q;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wdata_o = req_q;
    if (hit_q && req_q[MCAST_BIT])
      wdata_o[67:66] = req_q[67:66] | rd_data_i[67:66];
  end

  assign rd_addr_o = (state_q == S_COMMIT) ? sel_q : idx_q;
  assign active_o  = (state_q != S_IDLE);
  assign we_o      = (state_q == S_COMMIT) && !full_q;
  assign waddr_o   = sel_q;
  assign done_o    = done_q;
  assign full_o    = res_full_q;
  assign idx_o     = res_idx_q;
endmodule

// File: rtl/addr_tbl_engine.sv
module addr_tbl_engine
  import atbl_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int NUM_PORTS = 3,
  parameter int AW        = 4,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_we_i,
  input  logic [AW-1:0]          reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  input  logic                   search_req_i,
  input  logic [67:0]            search_entry_i,
  output logic                   search_done_o,
  output logic                   search_full_o,
  output logic [IDX_W-1:0]       search_idx_o,
  output logic                   busy_o,
  output logic                   engine_en_o,
  output logic                   vlan_aware_o,
  output logic [2*NUM_PORTS-1:0] port_state_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [3:0]       w0_q;
  logic [31:0]      w1_q, w2_q;
  logic [IDX_W-1:0] tidx_q, clr_idx_q;
  logic             clearing_q;

  logic             scan_active, scan_we, scan_start, clr_start, tctl_wr;
  logic [IDX_W-1:0] scan_rd_addr, scan_waddr;
  entry_t           scan_wdata;

  logic             tbl_we;
  logic [IDX_W-1:0] tbl_waddr, tbl_raddr;
  entry_t           tbl_wdata, tbl_rdata;

  assign busy_o     = scan_active | clearing_q;
  assign clr_start  = reg_we_i && (reg_addr_i == AW'(REG_GCTL)) && reg_wdata_i[GCTL_CLR] && !busy_o;
  assign scan_start = search_req_i && engine_en_o && !busy_o && !clr_start;
  assign tctl_wr    = reg_we_i && (reg_addr_i == AW'(REG_TCTL)) && !busy_o;

  atbl_cfg #(.NUM_PORTS(NUM_PORTS), .AW(AW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .en_o        (engine_en_o),
    .vlan_o      (vlan_aware_o),
    .port_state_o(port_state_o)
  );

  atbl_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (scan_start),
    .entry_i  (search_entry_i),
    .rd_data_i(tbl_rdata),
    .rd_addr_o(scan_rd_addr),
    .active_o (scan_active),
    .we_o     (scan_we),
    .waddr_o  (scan_waddr),
    .wdata_o  (scan_wdata),
    .done_o   (search_done_o),
    .full_o   (search_full_o),
    .idx_o    (search_idx_o)
  );

  // write port: clear sweep, then placement commit, then register window
  always_comb begin
    tbl_we    = 1'b0;
    tbl_waddr = reg_wdata_i[IDX_W-1:0];
    tbl_wdata = {w0_q, w1_q, w2_q};
    if (clearing_q) begin
      tbl_we    = 1'b1;
      tbl_waddr = clr_idx_q;
      tbl_wdata = '0;
    end else if (scan_we) begin
      tbl_we    = 1'b1;
      tbl_waddr = scan_waddr;
      tbl_wdata = scan_wdata;
    end else if (tctl_wr && reg_wdata_i[TCTL_WR]) begin
      tbl_we    = 1'b1;
    end
  end

  assign tbl_raddr = scan_active ? scan_rd_addr : reg_wdata_i[IDX_W-1:0];

  atbl_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we),
    .waddr_i(tbl_waddr),
    .wdata_i(tbl_wdata),
    .raddr_i(tbl_raddr),
    .rdata_o(tbl_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clearing_q <= 1'b0;
      clr_idx_q  <= '0;
    end else if (clr_start) begin
      clearing_q <= 1'b1;
      clr_idx_q  <= '0;
    end else if (clearing_q) begin
      if (clr_idx_q == LAST_IDX) clearing_q <= 1'b0;
      clr_idx_q <= clr_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w0_q   <= '0;
      w1_q   <= '0;
      w2_q   <= '0;
      tidx_q <= '0;
    end else begin
      if (tctl_wr) begin
        tidx_q <= reg_wdata_i[IDX_W-1:0];
        if (!reg_wdata_i[TCTL_WR]) begin
          w0_q <= tbl_rdata[67:64];
          w1_q <= tbl_rdata[63:32];
          w2_q <= tbl_rdata[31:0];
        end
      end
      if (reg_we_i && (reg_addr_i == AW'(REG_W0))) w0_q <= reg_wdata_i[3:0];
      if (reg_we_i && (reg_addr_i == AW'(REG_W1))) w1_q <= reg_wdata_i;
      if (reg_we_i && (reg_addr_i == AW'(REG_W2))) w2_q <= reg_wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(REG_GCTL))
      reg_rdata_o = {engine_en_o, clearing_q, 27'd0, vlan_aware_o, 2'd0};
    else if (reg_addr_i == AW'(REG_TCTL))
      reg_rdata_o = {{(32-IDX_W){1'b0}}, tidx_q};
    else if (reg_addr_i == AW'(REG_W0))
      reg_rdata_o = {28'd0, w0_q};
    else if (reg_addr_i == AW'(REG_W1))
      reg_rdata_o = w1_q;
    else if (reg_addr_i == AW'(REG_W2))
      reg_rdata_o = w2_q;
    for (int p = 0; p < NUM_PORTS; p++)
      if (reg_addr_i == AW'(REG_PORT0 + p)) reg_rdata_o = {30'd0, port_state_o[2*p +: 2]};
  end
endmodule

// File: rtl/atbl_chk.sv
module atbl_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        search_req_i,
  input logic [67:0] search_entry_i,
  input logic        engine_en_o,
  input logic        busy_o,
  input logic        clr_start,
  input logic        search_done_o,
  input logic        search_full_o,
  input logic        scan_we,
  input logic        tbl_we,
  input logic [67:0] tbl_wdata,
  input logic        clearing_q
);
  logic [67:0] cap_q;
  int unsigned clr_cnt_q;
  logic        accept;

  assign accept = search_req_i && engine_en_o && !busy_o && !clr_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q     <= '0;
      clr_cnt_q <= 0;
    end else begin
      if (accept) cap_q <= search_entry_i;
      clr_cnt_q <= clearing_q ? clr_cnt_q + 1 : 0;
    end
  end

  assert_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);

  assert_ignore_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !engine_en_o && !clr_start) |=> !busy_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_done_o |=> !search_done_o);

  assert_done_after_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_done_o |-> $past(busy_o));

  assert_full_nowrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (search_done_o && search_full_o) |-> !$past(tbl_we));

  assert_mcast_merge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_we && cap_q[40]) |-> (((tbl_wdata[67:66] & cap_q[67:66]) == cap_q[67:66]) &&
                                (tbl_wdata[65:0] == cap_q[65:0])));

  assert_ucast_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_we && !cap_q[40]) |-> (tbl_wdata == cap_q));

  assert_clear_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clearing_q) |-> (clr_cnt_q == DEPTH));

  assert_clear_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clearing_q |-> busy_o);
endmodule

bind addr_tbl_engine atbl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .search_req_i  (search_req_i),
  .search_entry_i(search_entry_i),
  .engine_en_o   (engine_en_o),
  .busy_o        (busy_o),
  .clr_start     (clr_start),
  .search_done_o (search_done_o),
  .search_full_o (search_full_o),
  .scan_we       (scan_we),
  .tbl_we        (tbl_we),
  .tbl_wdata     (tbl_wdata),
  .clearing_q    (clearing_q)
);

// File: tb/addr_tbl_engine_tb.sv
`timescale 1ns/1ps
module addr_tbl_engine_tb;
  localparam int D  = 8;
  localparam int NP = 3;
  localparam int IW = 3;

  function automatic logic [67:0] mk(input logic [1:0] port, input logic [1:0] ut,
                                     input logic [1:0] typ, input logic [47:0] mac);
    return {port, 2'b00, ut, typ, 12'h000, mac};
  endfunction

  localparam logic [47:0] MA = 48'h0200_0000_00A1, MB = 48'h0200_0000_00B2,
                          MC = 48'h0200_0000_00C3, MD = 48'h0200_0000_00D4,
                          ME = 48'h0200_0000_00E5, MF = 48'h0100_5E00_0001,
                          MG = 48'h0200_0000_0107, MH = 48'h0200_0000_0208,
                          MJ = 48'h0200_0000_0309, MK = 48'h0200_0000_040A;

  typedef struct packed {
    logic [67:0] req;
    logic        full;
    logic        hit;
    logic [2:0]  idx;
    logic [67:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{mk(3,0,1,MC), 1'b0, 1'b1, 3'd3, mk(3,0,1,MC)},
    '{mk(0,0,1,MD), 1'b0, 1'b0, 3'd2, mk(0,0,1,MD)},
    '{mk(1,0,1,MG), 1'b0, 1'b0, 3'd5, mk(1,0,1,MG)},
    '{mk(2,0,1,MH), 1'b0, 1'b0, 3'd1, mk(2,0,1,MH)},
    '{mk(3,0,1,MJ), 1'b0, 1'b0, 3'd6, mk(3,0,1,MJ)},
    '{mk(0,0,1,MK), 1'b1, 1'b0, 3'd0, mk(0,0,1,MA)},
    '{mk(2,3,1,MF), 1'b0, 1'b1, 3'd7, mk(3,3,1,MF)}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic search_req = 1'b0;
  logic [67:0] search_entry = '0;
  logic search_done, search_full, busy, en, vlan;
  logic [IW-1:0] search_idx;
  logic [2*NP-1:0] port_state;

  int checks = 0, fails = 0, done_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  addr_tbl_engine #(.DEPTH(D), .NUM_PORTS(NP), .AW(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .search_req_i(search_req),
    .search_entry_i(search_entry), .search_done_o(search_done), .search_full_o(search_full),
    .search_idx_o(search_idx), .busy_o(busy), .engine_en_o(en), .vlan_aware_o(vlan),
    .port_state_o(port_state)
  );

  always @(negedge clk) if (search_done) done_cnt++;

  task automatic chk(input string req, input string what, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic wr_entry(input int idx, input logic [67:0] e);
    reg_wr(4'd2, {28'd0, e[67:64]});
    reg_wr(4'd3, e[63:32]);
    reg_wr(4'd4, e[31:0]);
    reg_wr(4'd1, 32'h8000_0000 | idx);
  endtask

  task automatic rd_entry(input int idx, output logic [67:0] e);
    logic [31:0] a, b, c;
    reg_wr(4'd1, idx);
    reg_rd(4'd2, a);
    reg_rd(4'd3, b);
    reg_rd(4'd4, c);
    e = {a[3:0], b, c};
  endtask

  task automatic do_search(input logic [67:0] e, output int lat, output logic got);
    @(negedge clk);
    search_req = 1'b1; search_entry = e;
    @(posedge clk);
    @(negedge clk);
    search_req = 1'b0;
    lat = 0; got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (search_done) begin got = 1'b1; break; end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [67:0] e;
    int lat, n, dc;
    logic got;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(4'd0, d); chk("R1", "gctl", d, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", search_done, 0);
    chk("R1", "port_state", port_state, 0);
    rd_entry(3, e); chk("R1", "entry3", e, 0);

    // R5 port control
    reg_wr(4'd8, 32'h3);
    reg_wr(4'd10, 32'hFFFF_FFF6);
    reg_rd(4'd8, d);  chk("R5", "port0", d, 3);
    reg_rd(4'd9, d);  chk("R5", "port1", d, 0);
    reg_rd(4'd10, d); chk("R5", "port2", d, 2);
    chk("R5", "port_state_o", port_state, 6'b10_00_11);

    // R4 global control
    reg_wr(4'd0, 32'h8000_0F04);
    reg_rd(4'd0, d); chk("R4", "gctl", d, 32'h8000_0004);
    chk("R4", "engine_en_o", en, 1);
    chk("R4", "vlan_aware_o", vlan, 1);

    // R2/R3 window
    reg_wr(4'd2, 32'hFFFF_FFF5);
    reg_rd(4'd2, d); chk("R2", "word0 mask", d, 5);
    wr_entry(5, 68'hA_1234_5678_9ABC_DEF0);
    rd_entry(0, e); chk("R3", "entry0", e, 0);
    rd_entry(5, e); chk("R3", "entry5", e, 68'hA_1234_5678_9ABC_DEF0);
    reg_rd(4'd1, d); chk("R3", "tctl idx", d, 5);

    // preload
    wr_entry(0, mk(0,0,1,MA));
    wr_entry(1, mk(1,3,1,MB));
    wr_entry(2, 68'd0);
    wr_entry(3, mk(2,1,3,MC));
    wr_entry(4, mk(0,0,2,MD));
    wr_entry(5, 68'd0);
    wr_entry(6, mk(1,1,1,ME));
    wr_entry(7, mk(1,0,1,MF));

    // R7 R8 R9 R11 placement vectors
    for (int v = 0; v < 7; v++) begin
      do_search(VECS[v].req, lat, got);
      chk("R11", $sformatf("v%0d done", v), got, 1);
      chk("R11", $sformatf("v%0d latency", v), lat, VECS[v].hit ? VECS[v].idx + 2 : D + 1);
      chk("R8", $sformatf("v%0d full", v), search_full, VECS[v].full);
      if (!VECS[v].full) chk("R7", $sformatf("v%0d idx", v), search_idx, VECS[v].idx);
      @(negedge clk);
      chk("R11", $sformatf("v%0d pulse", v), search_done, 0);
      rd_entry(VECS[v].idx, e);
      chk(v == 6 ? "R9" : "R7", $sformatf("v%0d entry", v), e, VECS[v].exp);
    end

    // R10 disabled engine ignores requests
    reg_wr(4'd0, 32'h0);
    dc = done_cnt;
    do_search(mk(0,0,1,MK), lat, got);
    chk("R10", "disabled done", got, 0);
    chk("R10", "disabled busy", busy, 0);
    chk("R10", "disabled count", done_cnt - dc, 0);
    reg_wr(4'd0, 32'h8000_0004);

    // R10 busy ignores request and window commit
    reg_wr(4'd2, 32'h0);
    reg_wr(4'd3, 32'h0);
    reg_wr(4'd4, 32'h0);
    dc = done_cnt;
    @(negedge clk);
    search_req = 1'b1; search_entry = mk(0,0,1,MK);
    @(negedge clk);
    search_entry = mk(0,0,1,MA);
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h8000_0000;
    @(negedge clk);
    search_req = 1'b0; reg_we = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10", "busy done count", done_cnt - dc, 1);
    chk("R8", "busy full", search_full, 1);
    rd_entry(0, e); chk("R10", "entry0 kept", e, mk(0,0,1,MA));

    // R6 clear
    reg_wr(4'd0, 32'hC000_0004);
    chk("R6", "busy at clear", busy, 1);
    reg_addr = 4'd0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      #0.5;
      if (!reg_rdata[30]) break;
      n++;
      @(negedge clk);
    end
    chk("R6", "clear cycles", n, D);
    reg_rd(4'd0, d); chk("R6", "gctl after", d, 32'h8000_0004);
    rd_entry(1, e); chk("R6", "entry1", e, 0);
    rd_entry(7, e); chk("R6", "entry7", e, 0);
    do_search(mk(1,0,1,MA), lat, got);
    chk("R7", "post-clear idx", search_idx, 0);
    chk("R11", "post-clear latency", lat, D + 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule